// File: doc/BRIEF.md
# Prescaled PWM Generator with Shadowed Settings

The block drives one pulse-width-modulated output from a system clock and three synchronous reference tick enables. The period is built in stages. A reference tick is selected. A non-binary pre-divider (1, 3, 5 or 6) and a power-of-two stage (2^m, m = 0..7) step a period counter. That counter runs over 64 counts in small mode or 512 counts in large mode. The output is high while the period counter is below the programmed duty value.

Settings come in through a byte-wide write port. The size, clock, divider, glitch-removal and duty registers are shadowed. A write to the sync address moves the whole shadow set into the active set. When the active glitch-removal bit is set, the move is held back until the period counter wraps. This keeps a period from mixing old and new settings. When the bit is clear, the move happens at once and a fresh period starts. The enable register is not shadowed and acts immediately.

Top module: `pwm_prescaled`

## Requirements
- R1: The output period is N x D x 2^m selected ticks. D is the divider, with code 0,1,2,3 in bits 5:4 of address 1 meaning 1,3,5,6. m is taken from bits 2:0 of address 1.
- R2: The clock field (bits 1:0 of address 0) selects the tick source: 1, 2 and 3 pick tick_i[0], tick_i[1] and tick_i[2]. Code 0 stops the period counter, and the output holds its level.
- R3: Bit 7 of address 0 set to 1 gives N = 512 (9-bit mode). Set to 0 it gives N = 64 (6-bit mode).
- R4: The output is high while the period count is below the duty value. In 9-bit mode the duty value is {address 4 bit 0, address 3}. In 6-bit mode it is bits 5:0 of address 3. A duty of 0 keeps the output low.
- R5: Writes to addresses 0 to 4 leave the output unchanged until a sync write: address 6 with bit 0 set.
- R6: With the active glitch-removal bit set, a sync takes effect at the clock edge where the period counter wraps. The bit is address 2 bit 0 and is 1 after reset.
- R7: With the active glitch-removal bit clear, a sync takes effect at the edge that samples the sync write, and the period restarts at count 0.
- R8: The enable bit is address 5 bit 0. While it is 0, the output is low and the counters are held at 0. A sync issued while disabled, or while the active clock field is 0, takes effect at once.
- R9: After reset the output is low, the enable is 0, every setting is 0 and glitch removal is 1.
- R10: The period counter never exceeds N-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 3 | Reference tick enables, one cycle wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| pwm_o | output | 1 | PWM output |

## Verification
A register write takes effect at the rising edge that samples it. Shadow writes, the enable bit and an immediate sync therefore show on pwm_o at the next falling edge. A deferred sync shows after the falling edge that follows the wrap edge. The bench keeps a behavioural model that steps at each rising edge on the same sampled inputs, and compares pwm_o with it at every falling edge. Directed checks measure high time and period in whole cycles between rising output edges. They skip one full period after a deferred sync so that the measured period is entirely under the new settings.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int CLK_W   = 2;
  localparam int DIV_W   = 2;
  localparam int EXP_W   = 3;
  localparam int CNT_W   = 9;
  localparam int SMALL_W = 6;
  localparam int NUM_REF = (1 << CLK_W) - 1;

  localparam logic [ADDR_W-1:0] A_SIZE = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV  = 3'd1;
  localparam logic [ADDR_W-1:0] A_TYPE = 3'd2;
  localparam logic [ADDR_W-1:0] A_DLO  = 3'd3;
  localparam logic [ADDR_W-1:0] A_DHI  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EN   = 3'd5;
  localparam logic [ADDR_W-1:0] A_SYNC = 3'd6;

  typedef struct packed {
    logic             size9;
    logic [CLK_W-1:0] clk_sel;
    logic [DIV_W-1:0] div_code;
    logic [EXP_W-1:0] expo;
    logic             glitch;
    logic [CNT_W-1:0] duty;
  } pwm_cfg_t;

  localparam pwm_cfg_t CFG_RST = '{size9: 1'b0, clk_sel: '0, div_code: '0,
                                   expo: '0, glitch: 1'b1, duty: '0};

  function automatic logic [2:0] div_value(input logic [DIV_W-1:0] code);
    case (code)
      2'd0:    div_value = 3'd1;
      2'd1:    div_value = 3'd3;
      2'd2:    div_value = 3'd5;
      default: div_value = 3'd6;
    endcase
  endfunction
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              wrap_i,
  output pwm_cfg_t          act_o,
  output logic              en_o,
  output logic              load_o,
  output logic              pending_o
);
  pwm_cfg_t sh_q, act_q;
  logic     en_q, pend_q, sync_w;

  assign sync_w = wr_en_i && (wr_addr_i == A_SYNC) && wr_data_i[0];
  // deferred transfer only matters while a period is actually running
  assign load_o = (sync_w || pend_q) &&
                  (!act_q.glitch || !en_q || (act_q.clk_sel == '0) || wrap_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= CFG_RST;
      act_q  <= CFG_RST;
      en_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (wr_en_i) begin
        case (wr_addr_i)
          A_SIZE: begin
            sh_q.size9   <= wr_data_i[7];
            sh_q.clk_sel <= wr_data_i[CLK_W-1:0];
          end
          A_DIV: begin
            sh_q.div_code <= wr_data_i[5:4];
            sh_q.expo     <= wr_data_i[EXP_W-1:0];
          end
          A_TYPE:  sh_q.glitch        <= wr_data_i[0];
          A_DLO:   sh_q.duty[7:0]     <= wr_data_i;
          A_DHI:   sh_q.duty[CNT_W-1] <= wr_data_i[0];
          A_EN:    en_q               <= wr_data_i[0];
          default: ;
        endcase
      end
      if (load_o) act_q <= sh_q;
      pend_q <= load_o ? 1'b0 : (pend_q | sync_w);
    end
  end

  assign act_o     = act_q;
  assign en_o      = en_q;
  assign pending_o = pend_q;
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int DIV_W = 2,
  parameter int EXP_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             tick_i,
  input  logic [DIV_W-1:0] div_code_i,
  input  logic [EXP_W-1:0] expo_i,
  output logic             step_o
);
  localparam int ECNT_W = (1 << EXP_W) - 1;

  logic [2:0]        div_cnt, div_lim;
  logic [ECNT_W-1:0] exp_cnt, exp_lim;
  logic              div_done, exp_done;

  assign div_lim  = pwm_pkg::div_value(div_code_i) - 3'd1;
  assign exp_lim  = ~({ECNT_W{1'b1}} << expo_i);
  assign div_done = (div_cnt == div_lim);
  assign exp_done = (exp_cnt == exp_lim);
  assign step_o   = tick_i && div_done && exp_done;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_cnt <= '0;
      exp_cnt <= '0;
    end else if (clr_i) begin
      div_cnt <= '0;
      exp_cnt <= '0;
    end else if (tick_i) begin
      if (div_done) begin
        div_cnt <= '0;
        exp_cnt <= exp_done ? '0 : exp_cnt + 1'b1;
      end else begin
        div_cnt <= div_cnt + 3'd1;
      end
    end
  end
endmodule

// File: rtl/pwm_period_cnt.sv
module pwm_period_cnt #(
  parameter int CNT_W   = 9,
  parameter int SMALL_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic             en_i,
  input  logic             size9_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic             wrap_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             pwm_o
);
  localparam logic [CNT_W-1:0] LIM_H = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] LIM_L = CNT_W'((1 << SMALL_W) - 1);

  logic [CNT_W-1:0] cnt_q, lim, duty_eff;

  assign lim      = size9_i ? LIM_H : LIM_L;
  assign duty_eff = size9_i ? duty_i : {{(CNT_W-SMALL_W){1'b0}}, duty_i[SMALL_W-1:0]};
  assign wrap_o   = step_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (clr_i)   cnt_q <= '0;
    else if (step_i)  cnt_q <= (cnt_q == lim) ? '0 : cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
  assign pwm_o = en_i && (cnt_q < duty_eff);
endmodule

// File: rtl/pwm_prescaled.sv
module pwm_prescaled
  import pwm_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_REF-1:0] tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              pwm_o
);
  pwm_cfg_t         act_cfg;
  logic             en, load, pending, wrap, step, clr, sel_tick;
  logic [CNT_W-1:0] cnt;
  logic [NUM_REF:0] tick_ext;

  // code 0 maps to a constant zero tick: counter halts
  assign tick_ext = {tick_i, 1'b0};
  assign sel_tick = tick_ext[act_cfg.clk_sel];
  assign clr      = !en || load;

  pwm_shadow_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .wrap_i(wrap), .act_o(act_cfg), .en_o(en), .load_o(load), .pending_o(pending)
  );

  pwm_prescaler #(.DIV_W(DIV_W), .EXP_W(EXP_W)) u_pre (
    .clk_i, .rst_ni, .clr_i(clr), .tick_i(sel_tick),
    .div_code_i(act_cfg.div_code), .expo_i(act_cfg.expo), .step_o(step)
  );

  pwm_period_cnt #(.CNT_W(CNT_W), .SMALL_W(SMALL_W)) u_cnt (
    .clk_i, .rst_ni, .clr_i(clr), .step_i(step), .en_i(en),
    .size9_i(act_cfg.size9), .duty_i(act_cfg.duty),
    .wrap_o(wrap), .cnt_o(cnt), .pwm_o(pwm_o)
  );
endmodule

// File: rtl/pwm_prescaled_chk.sv
module pwm_prescaled_chk
  import pwm_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [DATA_W-1:0] wr_data_i,
  input pwm_cfg_t          act_i,
  input logic              en_i,
  input logic              load_i,
  input logic              pending_i,
  input logic              wrap_i,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              pwm_o
);
  logic [CNT_W-1:0] duty_eff;
  assign duty_eff = act_i.size9 ? act_i.duty : {{(CNT_W-SMALL_W){1'b0}}, act_i.duty[SMALL_W-1:0]};

  assert_halt_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && (act_i.clk_sel == '0) && !load_i |=> $stable(cnt_i));

  assert_duty_zero_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (duty_eff == '0) |-> !pwm_o);

  assert_act_stable_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(act_i));

  assert_load_at_wrap_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && act_i.glitch && en_i && (act_i.clk_sel != '0) |-> wrap_i);

  assert_pending_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !pending_i);

  assert_sync_now_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (wr_addr_i == A_SYNC) && wr_data_i[0] && !act_i.glitch |-> load_i);

  assert_off_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_i == '0));

  assert_no_overflow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= (act_i.size9 ? CNT_W'((1 << CNT_W) - 1) : CNT_W'((1 << SMALL_W) - 1)));
endmodule

bind pwm_prescaled pwm_prescaled_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .act_i(act_cfg), .en_i(en), .load_i(load),
  .pending_i(pending), .wrap_i(wrap), .cnt_i(cnt), .pwm_o(pwm_o)
);

// File: tb/sim_pwm_prescaled.sv
module sim_pwm_prescaled;
  localparam int CLK_PERIOD = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] tick_i = '0;
  logic       wr_en_i = 1'b0;
  logic [2:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic       pwm_o;

  int    n_chk = 0, n_fail = 0, cyc = 0;
  bit    done = 1'b0;
  string cur_req = "R9";

  pwm_prescaled u0 (.clk_i, .rst_ni, .tick_i, .wr_en_i, .wr_addr_i, .wr_data_i, .pwm_o);

  initial forever #(CLK_PERIOD/2) clk_i = ~clk_i;

  // reference ticks: source 3 every cycle, source 2 every 3, source 1 every 7
  initial forever begin
    @(negedge clk_i);
    cyc++;
    tick_i = {1'b1, (cyc % 3) == 0, (cyc % 7) == 0};
  end

  // behavioural reference model
  int s_size, s_clk, s_div, s_exp, s_gl, s_duty;
  int a_size, a_clk, a_div, a_exp, a_gl, a_duty;
  int m_en, m_pend, m_pre, m_pc, t_len, n_len;
  bit tk, wrp, sw, ld;

  function automatic int div_of(int c);
    return (c == 0) ? 1 : (c == 1) ? 3 : (c == 2) ? 5 : 6;
  endfunction

  function automatic int model_out();
    int d;
    d = a_size ? a_duty : (a_duty % 64);
    return (m_en != 0 && m_pc < d) ? 1 : 0;
  endfunction

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      s_size = 0; s_clk = 0; s_div = 0; s_exp = 0; s_gl = 1; s_duty = 0;
      a_size = 0; a_clk = 0; a_div = 0; a_exp = 0; a_gl = 1; a_duty = 0;
      m_en = 0; m_pend = 0; m_pre = 0; m_pc = 0;
    end else begin
      tk    = (a_clk != 0) && tick_i[a_clk-1];
      t_len = div_of(a_div) << a_exp;
      n_len = a_size ? 512 : 64;
      wrp   = (m_en != 0) && tk && (m_pre == t_len - 1) && (m_pc == n_len - 1);
      sw    = wr_en_i && (wr_addr_i == 3'd6) && wr_data_i[0];
      ld    = (sw || m_pend != 0) && (a_gl == 0 || m_en == 0 || a_clk == 0 || wrp);
      if (m_en == 0 || ld) begin
        m_pre = 0; m_pc = 0;
      end else if (tk) begin
        if (m_pre == t_len - 1) begin
          m_pre = 0;
          m_pc  = (m_pc == n_len - 1) ? 0 : m_pc + 1;
        end else m_pre++;
      end
      m_pend = ld ? 0 : ((m_pend != 0 || sw) ? 1 : 0);
      if (ld) begin
        a_size = s_size; a_clk = s_clk; a_div = s_div;
        a_exp = s_exp; a_gl = s_gl; a_duty = s_duty;
      end
      if (wr_en_i) begin
        case (wr_addr_i)
          3'd0: begin s_size = wr_data_i[7]; s_clk = wr_data_i[1:0]; end
          3'd1: begin s_div = wr_data_i[5:4]; s_exp = wr_data_i[2:0]; end
          3'd2: s_gl = wr_data_i[0];
          3'd3: s_duty = (s_duty & 256) | wr_data_i;
          3'd4: s_duty = (s_duty & 255) | (wr_data_i[0] ? 256 : 0);
          3'd5: m_en = wr_data_i[0];
          default: ;
        endcase
      end
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk_i)
    if (rst_ni && !done) check(pwm_o === 1'(model_out()), cur_req, "pwm_o vs model", pwm_o, model_out());

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  // measure high time and period from one rising output edge to the next
  task automatic measure(int ep, int eh, string req, bit chk_it);
    int prev, h, l, guard;
    bit to;
    prev = pwm_o; guard = 0; to = 0;
    forever begin
      @(negedge clk_i);
      if (pwm_o && !prev) break;
      prev = pwm_o;
      if (++guard > 20000) begin to = 1; break; end
    end
    h = 0; l = 0;
    while (!to && pwm_o) begin h++; @(negedge clk_i); if (h > 20000) to = 1; end
    while (!to && !pwm_o) begin l++; @(negedge clk_i); if (l > 20000) to = 1; end
    if (chk_it) begin
      check(!to, req, "edge found", to, 0);
      check(h == eh, req, "high cycles", h, eh);
      check(h + l == ep, req, "period cycles", h + l, ep);
    end
  endtask

  task automatic hold_check(int n, logic lvl, string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (pwm_o !== lvl) bad++;
    end
    check(bad == 0, req, "cycles off level", bad, 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(pwm_o === 1'b0, "R9", "output after reset", pwm_o, 0);

    // shadow writes alone leave the output low
    cur_req = "R5";
    wr(3'd0, 8'h03); wr(3'd1, 8'h00); wr(3'd3, 8'd16); wr(3'd5, 8'h01);
    hold_check(20, 1'b0, "R5");
    // halted active clock: sync applies at once
    cur_req = "R8";
    wr(3'd6, 8'h01);
    check(pwm_o === 1'b1, "R8", "output right after sync while halted", pwm_o, 1);
    cur_req = "R1";
    measure(64, 16, "R1", 1);

    // duty change without sync has no effect
    cur_req = "R5";
    wr(3'd3, 8'd40);
    measure(64, 16, "R5", 1);
    // glitch removal on by default: deferred to wrap
    cur_req = "R6";
    wr(3'd6, 8'h01);
    check(pwm_o === 1'b1, "R6", "old period continues after sync", pwm_o, 1);
    measure(64, 40, "R6", 0);
    measure(64, 40, "R6", 1);

    // divider 3, exponent 2 -> 12 ticks per count
    cur_req = "R1";
    wr(3'd1, 8'h12); wr(3'd6, 8'h01);
    measure(768, 480, "R1", 0);
    measure(768, 480, "R1", 1);

    // 9-bit mode, duty 300
    cur_req = "R3";
    wr(3'd0, 8'h83); wr(3'd1, 8'h00); wr(3'd3, 8'h2C); wr(3'd4, 8'h01); wr(3'd6, 8'h01);
    measure(512, 300, "R3", 0);
    measure(512, 300, "R3", 1);

    // 6-bit mode ignores duty bits above 5: 0xFF -> 63
    cur_req = "R4";
    wr(3'd0, 8'h03); wr(3'd3, 8'hFF); wr(3'd6, 8'h01);
    measure(64, 63, "R4", 0);
    measure(64, 63, "R4", 1);

    // turn glitch removal off, then sync acts immediately
    cur_req = "R7";
    wr(3'd2, 8'h00); wr(3'd6, 8'h01);
    measure(64, 63, "R7", 0);
    measure(64, 63, "R7", 0);
    wr(3'd3, 8'd8);
    @(negedge clk_i); @(negedge clk_i);
    wr(3'd6, 8'h01);
    check(pwm_o === 1'b1, "R7", "fresh period right after sync", pwm_o, 1);
    measure(64, 8, "R7", 1);

    // zero duty stays low
    cur_req = "R4";
    wr(3'd3, 8'd0); wr(3'd6, 8'h01);
    hold_check(150, 1'b0, "R4");

    // source 2 ticks every 3 cycles
    cur_req = "R2";
    wr(3'd0, 8'h02); wr(3'd3, 8'd32); wr(3'd6, 8'h01);
    measure(192, 96, "R2", 1);
    // clock code 0 halts at count 0: output held high
    wr(3'd0, 8'h00); wr(3'd6, 8'h01);
    hold_check(100, 1'b1, "R2");

    // disable: low; sync while disabled with glitch removal on applies at once
    cur_req = "R8";
    wr(3'd2, 8'h01); wr(3'd6, 8'h01);
    wr(3'd5, 8'h00);
    hold_check(50, 1'b0, "R8");
    wr(3'd0, 8'h03); wr(3'd3, 8'd20); wr(3'd6, 8'h01);
    hold_check(10, 1'b0, "R8");
    wr(3'd5, 8'h01);
    check(pwm_o === 1'b1, "R8", "output after re-enable", pwm_o, 1);
    measure(64, 20, "R8", 1);

    // R10 range covered by the bound checker during all phases above
    done = 1'b1;
    summary();
    $finish;
  end
endmodule